// File: doc/BRIEF.md
# Dual-Path Sinc Decimator with Overcurrent Trip

This block turns a single-bit delta-sigma stream into two filtered results. The stream is sampled on every rising edge of the modulator clock. A third-order sinc path gives signed words for a control loop. Its decimation ratio is set at run time as a power of two, R = 2^`acc_log2`. A second-order sinc path runs alongside it at a fixed short ratio of 16. That path reacts within a few tens of clocks, and each of its results is compared against a programmable high and low limit. Crossing either limit latches a trip flag, and the flag stays set until software clears it.

Each input bit counts as 1 or 0. Each path removes half of its full-scale gain, so a stream with 50 % ones reads as zero. The accurate word is 25 bits wide and the fast word is 9 bits wide, both in two's complement.

Each path holds its own two-state sequencer. After reset the sequencer sits in `PH_FILL`. It leaves that state through transition `T_PRIMED` once as many decimation ticks as the filter order have gone by, and it then sits in `PH_RUN`, where every tick produces a strobed result. Transition `T_RESTART` returns it to `PH_FILL` and clears the whole filter. That transition is taken on reset, and for the accurate path also on any change of `acc_log2`.

Top module: `sinc_dual_filter`

## Requirements
- R1: With R = 2^`acc_log2`, a steady all-ones stream gives `acc_word` = +R³/2, an all-zeros stream gives −R³/2, and a repeating 0101 pattern gives 0.
- R2: In `PH_RUN`, `acc_valid` is a one-cycle pulse that repeats every R clock edges.
- R3: Reset clears both strobes, both words and all flags. The first `acc_valid` is seen after the 4R-th rising edge following reset release, because the first three ticks are discarded in `PH_FILL`.
- R4: A repeating pattern of three ones in four gives `acc_word` = +R³/4, and one in four gives −R³/4.
- R5: Any change of `acc_log2` takes `T_RESTART` at the next edge, which clears the accurate filter. The next `acc_valid` then follows 4R′ edges after that clearing edge, where R′ is the new ratio.
- R6: The fast path decimates by 16 with a second-order sinc. Its first `fast_valid` comes after edge 48 following reset, and then one comes every 16 edges. `fast_word` spans −128 (all zeros) to +128 (all ones), and reads +64 and −64 for densities of 3/4 and 1/4.
- R7: `trip_hi` becomes set on the edge that ends a `fast_valid` cycle in which `fast_word` > `thr_hi`, a signed comparison. Equality does not set it, and once set it stays set.
- R8: `trip_lo` follows the same rule for `fast_word` < `thr_lo`, with equality not setting it.
- R9: `trip_clr` clears both trip flags at the next edge. A trip set in that same cycle wins over the clear. `ocd_flag` is high whenever either trip flag is set.
- R10: An `acc_log2` above 8 acts as 8, and 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mod_bit | input | 1 | Modulator output bit |
| acc_log2 | input | 4 | Log2 of the accurate-path decimation ratio |
| thr_hi | input | 9 | Signed upper trip limit |
| thr_lo | input | 9 | Signed lower trip limit |
| trip_clr | input | 1 | Clears both trip flags |
| acc_word | output | 25 | Signed accurate-path result |
| acc_valid | output | 1 | One-cycle strobe for `acc_word` |
| fast_word | output | 9 | Signed fast-path result |
| fast_valid | output | 1 | One-cycle strobe for `fast_word` |
| trip_hi | output | 1 | Sticky flag: high limit crossed |
| trip_lo | output | 1 | Sticky flag: low limit crossed |
| ocd_flag | output | 1 | Overcurrent indication |

## Verification
The following are checked on every cycle by properties:
- Strobes are single-cycle.
- The fast word stays within ±128.
- A trip flag only rises after a fast sample that really crossed its limit.
- A set flag holds until cleared.
- A clear with no sample pending drops both flags.

Only the directed scenarios can show the exact result values for each bit density, the edge counts that lead up to the first strobe after reset or after a ratio change, the clamping of out-of-range ratios, and the strict comparisons at the limits.

// File: rtl/sdf_pkg.sv
package sdf_pkg;
    localparam int ACC_ORDER  = 3;
    localparam int FAST_ORDER = 2;

    typedef enum logic {
        PH_FILL = 1'b0,
        PH_RUN  = 1'b1
    } phase_t;
endpackage

// File: rtl/sdf_sinc_path.sv
module sdf_sinc_path
    import sdf_pkg::*;
#(
    parameter  int ORDER    = 3,
    parameter  int MAX_LOG2 = 8,
    localparam int W        = ORDER * MAX_LOG2 + 1,
    localparam int EW       = $clog2(MAX_LOG2 + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                restart,
    input  logic [EW-1:0]       ratio_log2,
    input  logic                in_bit,
    output logic signed [W-1:0] result,
    output logic                result_valid
);
    localparam int CW = MAX_LOG2;
    localparam int FW = $clog2(ORDER + 1);

    logic [EW-1:0] eff_log2;
    logic [CW-1:0] last_cnt;
    logic [CW-1:0] dec_cnt;
    logic          tick;
    logic [W-1:0]  offset;
    logic [W-1:0]  integ  [ORDER];
    logic [W-1:0]  feed   [ORDER];
    logic [W-1:0]  cdly   [ORDER];
    logic [W-1:0]  cstage [ORDER+1];
    phase_t        state_q, state_d;
    logic [FW-1:0] fill_q;

    // ratio clamp: 0 acts as 1, above MAX_LOG2 acts as MAX_LOG2
    always_comb begin
        if (ratio_log2 == '0)
            eff_log2 = EW'(1);
        else if (32'(ratio_log2) > MAX_LOG2)
            eff_log2 = EW'(MAX_LOG2);
        else
            eff_log2 = ratio_log2;
    end

    assign last_cnt = CW'((32'd1 << eff_log2) - 32'd1);
    assign tick     = (dec_cnt == last_cnt);
    assign offset   = W'(64'd1 << (ORDER * 32'(eff_log2) - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            dec_cnt <= '0;
        else if (restart || tick)
            dec_cnt <= '0;
        else
            dec_cnt <= dec_cnt + 1'b1;
    end

    // integrator chain at the bit rate
    always_comb begin
        feed[0] = W'(in_bit);
        for (int k = 1; k < ORDER; k++)
            feed[k] = integ[k-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < ORDER; k++)
                integ[k] <= '0;
        end else begin
            for (int k = 0; k < ORDER; k++)
                integ[k] <= restart ? '0 : integ[k] + feed[k];
        end
    end

    // comb chain at the decimated rate
    always_comb begin
        cstage[0] = integ[ORDER-1];
        for (int k = 0; k < ORDER; k++)
            cstage[k+1] = cstage[k] - cdly[k];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < ORDER; k++)
                cdly[k] <= '0;
        end else if (restart) begin
            for (int k = 0; k < ORDER; k++)
                cdly[k] <= '0;
        end else if (tick) begin
            for (int k = 0; k < ORDER; k++)
                cdly[k] <= cstage[k];
        end
    end

    // sequencer: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= PH_FILL;
        else if (restart)
            state_q <= PH_FILL;          // T_RESTART
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_FILL: if (tick && fill_q == FW'(ORDER - 1)) state_d = PH_RUN; // T_PRIMED
            PH_RUN:  state_d = PH_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            fill_q <= '0;
        else if (restart)
            fill_q <= '0;
        else if (tick && state_q == PH_FILL)
            fill_q <= fill_q + 1'b1;
    end

    // sequencer: outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result       <= '0;
            result_valid <= 1'b0;
        end else if (restart) begin
            result       <= '0;
            result_valid <= 1'b0;
        end else begin
            result_valid <= tick && (state_q == PH_RUN);
            if (tick)
                result <= $signed(cstage[ORDER] - offset);
        end
    end
endmodule

// File: rtl/sinc_dual_filter.sv
module sinc_dual_filter
    import sdf_pkg::*;
#(
    parameter  int ACC_MAX_LOG2 = 8,
    parameter  int FAST_LOG2    = 4,
    localparam int ACC_W        = ACC_ORDER * ACC_MAX_LOG2 + 1,
    localparam int FAST_W       = FAST_ORDER * FAST_LOG2 + 1,
    localparam int RW           = $clog2(ACC_MAX_LOG2 + 1),
    localparam int FEW          = $clog2(FAST_LOG2 + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     mod_bit,
    input  logic [RW-1:0]            acc_log2,
    input  logic signed [FAST_W-1:0] thr_hi,
    input  logic signed [FAST_W-1:0] thr_lo,
    input  logic                     trip_clr,
    output logic signed [ACC_W-1:0]  acc_word,
    output logic                     acc_valid,
    output logic signed [FAST_W-1:0] fast_word,
    output logic                     fast_valid,
    output logic                     trip_hi,
    output logic                     trip_lo,
    output logic                     ocd_flag
);
    logic [RW-1:0] ratio_q;
    logic          acc_restart;
    logic          set_hi, set_lo;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ratio_q <= acc_log2;
        else
            ratio_q <= acc_log2;
    end

    assign acc_restart = (acc_log2 != ratio_q);

    sdf_sinc_path #(
        .ORDER    (ACC_ORDER),
        .MAX_LOG2 (ACC_MAX_LOG2)
    ) u_acc (
        .clk          (clk),
        .rst_n        (rst_n),
        .restart      (acc_restart),
        .ratio_log2   (acc_log2),
        .in_bit       (mod_bit),
        .result       (acc_word),
        .result_valid (acc_valid)
    );

    sdf_sinc_path #(
        .ORDER    (FAST_ORDER),
        .MAX_LOG2 (FAST_LOG2)
    ) u_fast (
        .clk          (clk),
        .rst_n        (rst_n),
        .restart      (1'b0),
        .ratio_log2   (FEW'(FAST_LOG2)),
        .in_bit       (mod_bit),
        .result       (fast_word),
        .result_valid (fast_valid)
    );

    assign set_hi = fast_valid && (fast_word > thr_hi);
    assign set_lo = fast_valid && (fast_word < thr_lo);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trip_hi <= 1'b0;
            trip_lo <= 1'b0;
        end else begin
            trip_hi <= set_hi | (trip_hi & ~trip_clr);
            trip_lo <= set_lo | (trip_lo & ~trip_clr);
        end
    end

    assign ocd_flag = trip_hi | trip_lo;
endmodule

// File: rtl/sdf_checker.sv
module sdf_checker #(
    parameter int FAST_W    = 9,
    parameter int FAST_LOG2 = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     acc_valid,
    input logic                     fast_valid,
    input logic signed [FAST_W-1:0] fast_word,
    input logic signed [FAST_W-1:0] thr_hi,
    input logic signed [FAST_W-1:0] thr_lo,
    input logic                     trip_clr,
    input logic                     trip_hi,
    input logic                     trip_lo
);
    localparam int FAST_LIM = 1 << (2 * FAST_LOG2 - 1);

    a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> !acc_valid);

    a_r6_fast_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        fast_valid |-> (int'(fast_word) <= FAST_LIM && int'(fast_word) >= -FAST_LIM));

    a_r7_hi_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trip_hi) |-> ($past(fast_valid) && $past(fast_word) > $past(thr_hi)));

    a_r8_lo_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trip_lo) |-> ($past(fast_valid) && $past(fast_word) < $past(thr_lo)));

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (trip_hi && !trip_clr) |=> trip_hi);

    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (trip_clr && !fast_valid) |=> (!trip_hi && !trip_lo));
endmodule

bind sinc_dual_filter sdf_checker #(
    .FAST_W    (FAST_W),
    .FAST_LOG2 (FAST_LOG2)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .fast_valid (fast_valid),
    .fast_word  (fast_word),
    .thr_hi     (thr_hi),
    .thr_lo     (thr_lo),
    .trip_clr   (trip_clr),
    .trip_hi    (trip_hi),
    .trip_lo    (trip_lo)
);

// File: tb/sim_sinc_dual_filter.sv
`timescale 1ns/1ps
module sim_sinc_dual_filter;
    localparam int CLK_P = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              mod_bit = 1'b0;
    logic [3:0]        acc_log2 = 4'd4;
    logic signed [8:0] thr_hi = 9'sd200;
    logic signed [8:0] thr_lo = -9'sd200;
    logic              trip_clr = 1'b0;
    logic signed [24:0] acc_word;
    logic              acc_valid;
    logic signed [8:0] fast_word;
    logic              fast_valid;
    logic              trip_hi, trip_lo, ocd_flag;

    logic [3:0] pat = 4'b1111;
    int ph = 0;
    int n_cmp = 0;
    int n_bad = 0;

    sinc_dual_filter u0 (
        .clk(clk), .rst_n(rst_n), .mod_bit(mod_bit), .acc_log2(acc_log2),
        .thr_hi(thr_hi), .thr_lo(thr_lo), .trip_clr(trip_clr),
        .acc_word(acc_word), .acc_valid(acc_valid),
        .fast_word(fast_word), .fast_valid(fast_valid),
        .trip_hi(trip_hi), .trip_lo(trip_lo), .ocd_flag(ocd_flag)
    );

    initial forever #(CLK_P/2) clk = ~clk;

    initial forever begin
        @(negedge clk);
        mod_bit = pat[ph];
        ph = (ph + 1) % 4;
    end

    task automatic chk(input string req, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_acc(output int edges);
        edges = 0;
        forever begin
            @(posedge clk);
            edges++;
            @(negedge clk);
            if (acc_valid) break;
        end
    endtask

    task automatic wait_fast();
        forever begin
            @(posedge clk);
            @(negedge clk);
            if (fast_valid) break;
        end
    endtask

    task automatic skip_acc(input int k);
        int e;
        for (int i = 0; i < k; i++) wait_acc(e);
    endtask

    task automatic t_reset();
        int e = 0, ea = 0, ef = 0;
        longint aw = 0, fw = 0;
        pat = 4'b1111;
        repeat (3) @(negedge clk);
        chk("R3 reset acc_valid", acc_valid, 0);
        chk("R3 reset fast_valid", fast_valid, 0);
        chk("R3 reset acc_word", acc_word, 0);
        chk("R3 reset ocd_flag", ocd_flag, 0);
        rst_n = 1'b1;
        while ((ea == 0 || ef == 0) && e < 400) begin
            @(posedge clk);
            e++;
            @(negedge clk);
            if (acc_valid && ea == 0) begin ea = e; aw = acc_word; end
            if (fast_valid && ef == 0) begin ef = e; fw = fast_word; end
        end
        chk("R3 first acc_valid edge", ea, 64);
        chk("R6 first fast_valid edge", ef, 48);
        chk("R1 all-ones acc_word", aw, 2048);
        chk("R6 all-ones fast_word", fw, 128);
        chk("R7 no trip below limit", ocd_flag, 0);
    endtask

    task automatic t_rate();
        int e;
        wait_acc(e);
        chk("R2 acc word spacing", e, 16);
        @(negedge clk);
        chk("R2 strobe one cycle", acc_valid, 0);
    endtask

    task automatic t_density(input logic [3:0] p, input longint ea, input longint ef,
                             input string tag);
        @(negedge clk);
        pat = p;
        skip_acc(5);
        chk({tag, " acc_word"}, acc_word, ea);
        wait_fast();
        chk({tag, " fast_word"}, fast_word, ef);
    endtask

    task automatic t_trip_hi();
        pat = 4'b0111;
        repeat (4) wait_fast();
        thr_hi = 9'sd64;
        repeat (2) wait_fast();
        @(negedge clk);
        chk("R7 equal does not trip", trip_hi, 0);
        thr_hi = 9'sd63;
        wait_fast();
        chk("R7 not yet set in sample cycle", trip_hi, 0);
        @(negedge clk);
        chk("R7 trip_hi set", trip_hi, 1);
        chk("R9 ocd_flag from hi", ocd_flag, 1);
        thr_hi = 9'sd200;
        repeat (2) wait_fast();
        @(negedge clk);
        chk("R7 trip_hi sticky", trip_hi, 1);
        trip_clr = 1'b1;
        @(negedge clk);
        trip_clr = 1'b0;
        chk("R9 clear trip_hi", trip_hi, 0);
        chk("R9 ocd_flag cleared", ocd_flag, 0);
    endtask

    task automatic t_trip_lo();
        pat = 4'b0001;
        repeat (4) wait_fast();
        thr_lo = -9'sd64;
        repeat (2) wait_fast();
        @(negedge clk);
        chk("R8 equal does not trip", trip_lo, 0);
        thr_lo = -9'sd63;
        wait_fast();
        @(negedge clk);
        chk("R8 trip_lo set", trip_lo, 1);
        chk("R8 trip_hi untouched", trip_hi, 0);
        trip_clr = 1'b1;
        @(negedge clk);
        chk("R9 clear trip_lo", trip_lo, 0);
        wait_fast();
        @(negedge clk);
        chk("R9 set wins over clear", trip_lo, 1);
        @(negedge clk);
        chk("R9 held clear drops flag", trip_lo, 0);
        trip_clr = 1'b0;
        thr_lo = -9'sd200;
    endtask

    task automatic t_ratio(input logic [3:0] l2, input int first_e, input longint val,
                           input string tag);
        int e;
        @(negedge clk);
        pat = 4'b1111;
        acc_log2 = l2;
        @(posedge clk);
        wait_acc(e);
        chk({tag, " first strobe after change"}, e, first_e);
        chk({tag, " all-ones word"}, acc_word, val);
    endtask

    initial begin
        int e;
        t_reset();
        t_rate();
        t_density(4'b0000, -2048, -128, "R1 all-zeros");
        t_density(4'b0101, 0, 0, "R1 half density");
        t_density(4'b0111, 1024, 64, "R4 three-quarter");
        t_density(4'b0001, -1024, -64, "R4 one-quarter");
        t_trip_hi();
        t_trip_lo();
        t_ratio(4'd5, 128, 16384, "R5 ratio 32");
        t_ratio(4'd15, 1024, 8388608, "R10 clamp high");
        wait_acc(e);
        chk("R10 clamp high spacing", e, 256);
        t_ratio(4'd0, 8, 4, "R10 clamp zero");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule